// File: doc/BRIEF.md
# Banked program memory address mapper

This block sits between a CPU's program-memory access paths and a 128 KB flash code store built as four 32 KB banks. It turns 16-bit CPU addresses into physical flash addresses. The low half of the CPU space always reaches bank 0. The high half reaches one of banks 1 to 3. Two separate bank selects decide which upper bank is used: one for instruction fetch and one for data-style flash reads and writes. The same CPU address can therefore reach different physical banks depending on which path issued it.

A data access can instead target a small data-only scratch area above the flash. Flash writes go through only while a program-store write enable is set. Any access to the reserved last kilobyte of bank 3 is refused and reported as a fault. Each result is registered and comes out one cycle after the request, together with the 1 KB sector index. When a fetch and a data access arrive in the same cycle, the fetch is served and the data path is told to retry on the next cycle.

Top module: `pmem_bank_map`

## Requirements
- R1: After reset no result is valid or faulted, both bank selects point at bank 1, and the write enable is clear.
- R2: CPU addresses 0x0000 to 0x7FFF map to the same physical address (bank 0) for fetch and data, whatever the selects hold.
- R3: A fetch at CPU address 0x8000 to 0xFFFF maps to fetch_bank*0x8000 + addr[14:0]; a select value of 0 acts as bank 1.
- R4: A data access in the upper window uses the data select, independently of the fetch select, with the same rule for value 0.
- R5: A config write with cfg_sel=0 loads the fetch select from cfg_wdata[1:0] and the data select from cfg_wdata[3:2]; cfg_sel=1 loads the write enable from cfg_wdata[0]. A write affects accesses from the next cycle; an access in the same cycle uses the old value.
- R6: A data write while the write enable is clear gives out_valid=0 and out_fault=0; with the enable set it gives out_valid=1 and out_write=1.
- R7: Any access whose physical address is 0x1FC00 to 0x1FFFF (fetch, read or write) gives out_fault=1 and out_valid=0.
- R8: A data access with data_scratch=1 maps to 0x20000 + addr[7:0] and faults if addr[15:8] is not zero; a fetch never yields an address at or above 0x20000.
- R9: out_sector equals physical address bits [16:10].
- R10: When fetch_req and data_req are both high, data_stall is high in that cycle and the result in the next cycle is the fetch's.
- R11: Results appear in the cycle after the request; a cycle with no request gives out_valid=0 and out_fault=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 1 | 0: bank select register, 1: write enable register |
| cfg_wdata | input | 4 | Config write data |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Fetch CPU address |
| data_req | input | 1 | Data-style access request |
| data_we | input | 1 | Data access is a write |
| data_scratch | input | 1 | Data access targets the scratch area |
| data_addr | input | 16 | Data CPU address |
| data_stall | output | 1 | Data request not served this cycle, retry |
| out_valid | output | 1 | Registered result may be performed |
| out_fault | output | 1 | Registered result hit a blocked region |
| out_fetch | output | 1 | Result belongs to a fetch |
| out_write | output | 1 | Result is a write |
| out_addr | output | 18 | Physical address |
| out_sector | output | 7 | 1 KB sector index of the physical address |

## Verification
Two things can coincide: a fetch and a data access in one cycle, and a config write with an access in that cycle. The bench drives both pairs on purpose, with a config change together with a fetch whose mapping depends on it, and a fetch together with a data access, then repeats them under random stimulus. A behavioural model judges each cycle: the colliding data access must see data_stall and no service, the fetch's result must appear, and the access beside the config write must use the select values from before the write.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    localparam int CPU_AW    = 16;
    localparam int BSEL_W    = 2;
    localparam int WIN_AW    = CPU_AW - 1;
    localparam int FLASH_AW  = WIN_AW + BSEL_W;
    localparam int PHYS_AW   = FLASH_AW + 1;
    localparam int SECT_LOG2 = 10;
    localparam int SECT_W    = FLASH_AW - SECT_LOG2;
    localparam int SCR_AW    = 8;
    localparam int CFG_DW    = 2 * BSEL_W;

    typedef struct packed {
        logic [BSEL_W-1:0] fetch_bank;
        logic [BSEL_W-1:0] data_bank;
        logic              prog_wen;
    } bank_cfg_t;

    typedef struct packed {
        logic               valid;
        logic               fault;
        logic               is_fetch;
        logic               is_write;
        logic [PHYS_AW-1:0] addr;
    } map_res_t;
endpackage

// File: rtl/pmb_cfg.sv
module pmb_cfg
    import pmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [CFG_DW-1:0] wdata,
    output bank_cfg_t         cfg
);
    bank_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (!sel) begin
                cfg_d.fetch_bank = wdata[BSEL_W-1:0];
                cfg_d.data_bank  = wdata[CFG_DW-1:BSEL_W];
            end else begin
                cfg_d.prog_wen = wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.fetch_bank <= {{(BSEL_W-1){1'b0}}, 1'b1};
            cfg_q.data_bank  <= {{(BSEL_W-1){1'b0}}, 1'b1};
            cfg_q.prog_wen   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pmb_xlate.sv
module pmb_xlate
    import pmb_pkg::*;
(
    input  logic              req,
    input  logic              is_fetch,
    input  logic              is_write,
    input  logic              scratch,
    input  logic              prog_wen,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BSEL_W-1:0] bank_sel,
    output map_res_t          res
);
    logic [BSEL_W-1:0]  bank;
    logic [PHYS_AW-1:0] pa;
    logic               blocked;
    logic               wr_off;

    always_comb begin
        bank = '0;
        if (cpu_addr[CPU_AW-1]) begin
            bank = (bank_sel == '0) ? {{(BSEL_W-1){1'b0}}, 1'b1} : bank_sel;
        end
        if (scratch) begin
            pa      = {1'b1, {(PHYS_AW-1-SCR_AW){1'b0}}, cpu_addr[SCR_AW-1:0]};
            blocked = |cpu_addr[CPU_AW-1:SCR_AW];
        end else begin
            pa      = {1'b0, bank, cpu_addr[WIN_AW-1:0]};
            blocked = &pa[FLASH_AW-1:SECT_LOG2];
        end
        wr_off       = is_write & ~prog_wen;
        res.valid    = req & ~blocked & ~wr_off;
        res.fault    = req & blocked;
        res.is_fetch = req & is_fetch;
        res.is_write = req & is_write;
        res.addr     = req ? pa : '0;
    end
endmodule

// File: rtl/pmem_bank_map.sv
module pmem_bank_map
    import pmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic                fetch_req,
    input  logic [CPU_AW-1:0]   fetch_addr,
    input  logic                data_req,
    input  logic                data_we,
    input  logic                data_scratch,
    input  logic [CPU_AW-1:0]   data_addr,
    output logic                data_stall,
    output logic                out_valid,
    output logic                out_fault,
    output logic                out_fetch,
    output logic                out_write,
    output logic [PHYS_AW-1:0]  out_addr,
    output logic [SECT_W-1:0]   out_sector
);
    bank_cfg_t cfg;
    map_res_t  f_res, d_res;
    map_res_t  res_d, res_q;

    pmb_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    pmb_xlate u_fetch_map (
        .req      (fetch_req),
        .is_fetch (1'b1),
        .is_write (1'b0),
        .scratch  (1'b0),
        .prog_wen (1'b0),
        .cpu_addr (fetch_addr),
        .bank_sel (cfg.fetch_bank),
        .res      (f_res)
    );

    pmb_xlate u_data_map (
        .req      (data_req),
        .is_fetch (1'b0),
        .is_write (data_we),
        .scratch  (data_scratch),
        .prog_wen (cfg.prog_wen),
        .cpu_addr (data_addr),
        .bank_sel (cfg.data_bank),
        .res      (d_res)
    );

    always_comb begin
        res_d = '0;
        if (fetch_req) begin
            res_d = f_res;
        end else if (data_req) begin
            res_d = d_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign data_stall = fetch_req & data_req;
    assign out_valid  = res_q.valid;
    assign out_fault  = res_q.fault;
    assign out_fetch  = res_q.is_fetch;
    assign out_write  = res_q.is_write;
    assign out_addr   = res_q.addr;
    assign out_sector = res_q.addr[FLASH_AW-1:SECT_LOG2];
endmodule

// File: rtl/pmem_bank_map_chk.sv
module pmem_bank_map_chk
    import pmb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_req,
    input logic [CPU_AW-1:0]  fetch_addr,
    input logic               data_req,
    input logic               data_stall,
    input logic               out_valid,
    input logic               out_fault,
    input logic               out_fetch,
    input logic [PHYS_AW-1:0] out_addr
);
    assert_lower_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_addr[CPU_AW-1]) |=> (out_addr == PHYS_AW'($past(fetch_addr))));

    assert_upper_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_addr[CPU_AW-1]) |=> (out_addr[FLASH_AW-1:WIN_AW] != '0));

    assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> !out_valid);

    assert_fetch_flash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fetch |-> !out_addr[PHYS_AW-1]);

    assert_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_stall |=> out_fetch);

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !data_req) |=> (!out_valid && !out_fault));
endmodule

bind pmem_bank_map pmem_bank_map_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .data_req   (data_req),
    .data_stall (data_stall),
    .out_valid  (out_valid),
    .out_fault  (out_fault),
    .out_fetch  (out_fetch),
    .out_addr   (out_addr)
);

// File: tb/pmem_bank_map_tb_top.sv
module pmem_bank_map_tb_top;
    import pmb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cfg_we, cfg_sel, fetch_req, data_req, data_we, data_scratch;
    logic [CFG_DW-1:0] cfg_wdata;
    logic [CPU_AW-1:0] fetch_addr, data_addr;
    logic data_stall, out_valid, out_fault, out_fetch, out_write;
    logic [PHYS_AW-1:0] out_addr;
    logic [SECT_W-1:0] out_sector;

    pmem_bank_map dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    int fb, db, wen;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int map_flash(input int a, input int bank);
        int b;
        if (a < 32768) return a;
        b = (bank == 0) ? 1 : bank;
        return b * 32768 + (a - 32768);
    endfunction

    task automatic cyc(input bit fr, input int fa, input bit dr, input bit dw,
                       input bit ds, input int da, input bit cw, input bit cs,
                       input int cd, input string tag);
        bit ev, ef, efe, ew;
        int ea, act, exp;
        bit ok;
        fetch_req = fr; fetch_addr = fa[15:0];
        data_req = dr; data_we = dw; data_scratch = ds; data_addr = da[15:0];
        cfg_we = cw; cfg_sel = cs; cfg_wdata = cd[3:0];
        #1;
        check(data_stall === (fr && dr), tag, "stall", int'(data_stall), int'(fr && dr));
        ev = 0; ef = 0; efe = 0; ew = 0; ea = 0;
        if (fr) begin
            ea = map_flash(fa, fb);
            ef = (ea >= 'h1FC00 && ea < 'h20000);
            ev = !ef; efe = 1;
        end else if (dr) begin
            if (ds) begin
                ea = 'h20000 + (da % 256);
                ef = (da >= 256);
            end else begin
                ea = map_flash(da, db);
                ef = (ea >= 'h1FC00 && ea < 'h20000);
            end
            ew = dw;
            ev = !ef && !(dw && wen == 0);
        end
        if (cw) begin
            if (!cs) begin fb = cd & 3; db = (cd >> 2) & 3; end
            else wen = cd & 1;
        end
        @(posedge clk);
        @(negedge clk);
        ok = (out_valid === ev) && (out_fault === ef);
        if (ev || ef)
            ok = ok && (int'(out_addr) == ea) && (out_fetch === efe) && (out_write === ew)
                    && (int'(out_sector) == ((ea >> 10) & 127));
        act = (int'(out_valid) << 22) | (int'(out_fault) << 21) | (int'(out_sector) << 18) | int'(out_addr);
        exp = (int'(ev) << 22) | (int'(ef) << 21) | (((ea >> 10) & 127) << 18) | ea;
        check(ok, tag, "result", act, exp);
        fetch_req = 0; data_req = 0; cfg_we = 0;
    endtask

    task automatic do_fetch(input int a, input string tag);
        cyc(1, a, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic do_data(input bit w, input bit s, input int a, input string tag);
        cyc(0, 0, 1, w, s, a, 0, 0, 0, tag);
    endtask
    task automatic do_cfg(input bit s, input int d, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, s, d, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
        fetch_req = 0; fetch_addr = '0; data_req = 0; data_we = 0;
        data_scratch = 0; data_addr = '0;
        fb = 1; db = 1; wen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_fault === 1'b0, "R1", "reset outputs",
              int'({out_valid, out_fault}), 0);
        do_fetch('h8000, "R1");
        do_data(0, 0, 'h8000, "R1");
        do_data(1, 0, 'h8004, "R1");
        cyc(1, 'h9234, 0, 0, 0, 0, 1, 0, 'hE, "R5");
        do_fetch('h9234, "R3");
        do_data(0, 0, 'h9234, "R4");
        do_fetch('h1234, "R2");
        do_data(0, 0, 'h7FFF, "R2");
        cyc(0, 0, 1, 0, 0, 'hA000, 1, 0, 'hC, "R5");
        do_fetch('hC000, "R3");
        do_data(0, 0, 'hA000, "R4");
        do_data(1, 0, 'h8010, "R6");
        do_cfg(1, 1, "R5");
        do_data(1, 0, 'h8010, "R6");
        do_data(0, 0, 'hFC00, "R7");
        do_data(0, 0, 'hFFFF, "R7");
        do_data(0, 0, 'hFBFF, "R9");
        do_cfg(0, 'hF, "R5");
        do_fetch('hFE00, "R7");
        do_fetch('hF800, "R9");
        do_data(1, 0, 'hFC00, "R7");
        do_data(0, 1, 'h0042, "R8");
        do_data(1, 1, 'h00FF, "R8");
        do_data(0, 1, 'h0100, "R8");
        cyc(1, 'h0100, 1, 0, 0, 'h8000, 0, 0, 0, "R10");
        do_data(0, 0, 'h8000, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        do_cfg(1, 0, "R5");
        do_data(1, 1, 'h0010, "R6");
        for (int i = 0; i < 600; i++) begin
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 65535),
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 5) == 0,
                ($urandom_range(0, 3) == 0) ? $urandom_range(0, 300) : $urandom_range(0, 65535),
                $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 15), "R3 R4 R10 random");
        end
        finish_run();
    end
endmodule